// File: doc/BRIEF.md
# Event Flag Interrupt Controller with Read-Window Hold

This block collects single-cycle event strobes into a sticky flag register and drives an active-low interrupt line when a set flag meets a set enable bit in a mask register. The line is a bounded one-shot pulse, not a level. After the pulse fires, the block ignores further events for interrupt purposes until software has read the mask byte and then written it again.

The serial-bus slave engine is outside the block. It reports a register read to the block through markers:
- the read direction has been decoded;
- the flag byte has gone out;
- the mask byte has gone out and been acknowledged;
- a stop condition was seen.

From the moment the read is decoded until the read ends, the flags are frozen. Events that arrive in that interval are parked and merged only after the clear that the read causes. Software can also leave every mask bit at zero and poll the flags.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the flag byte and mask byte are all zero and the interrupt line `irq_n_o` is high.
- R2: Outside a read window, a high bit `evt_i[i]` sets `flag_o[i]` on the same clock edge. A set flag stays set until a read clears it.
- R3: When an armed line sees a flag whose mask bit is 1, `irq_n_o` goes low one edge after that flag and mask are both registered. With all mask bits zero, the line stays high whatever the flags are.
- R4: A pulse holds `irq_n_o` low for exactly `PULSE_CYC` cycles, then releases it. Events during the pulse do not lengthen it.
- R5: After a pulse fires, further events, including repeats on a flag that is already set, produce no new pulse until the line is re-armed.
- R6: A mask write that enables a flag which is already set, on an armed line, fires the pulse one edge after the mask register updates.
- R7: A read that delivers both bytes (mask byte marker inside the window) clears every flag and every mask bit on that edge. It also ends a running pulse on that edge. An event on that same edge survives the clear.
- R8: A read that delivers only the flag byte and then ends with a stop clears every flag except the mask-read flags, and leaves the mask untouched. The mask-read flags are selected by `MRD_CLR`; by default these are bits 0 (tuning done) and 1 (band edge).
- R9: Events arriving while a read window is open leave `flag_o` unchanged. They are set once the window ends, after any clear. A window closed by a stop with no byte delivered clears nothing but still releases the parked events.
- R10: Re-arming needs a mask-byte read followed by a mask write. A mask write without a preceding mask-byte read does not re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NF | Event strobes, one per flag |
| rd_start_i | input | 1 | Read direction decoded; opens the read window |
| rd_flag_i | input | 1 | Flag byte has been delivered |
| rd_mask_i | input | 1 | Mask byte delivered and acknowledged |
| stop_i | input | 1 | Stop condition seen on the bus |
| mask_wr_i | input | 1 | Mask byte write strobe |
| mask_wdata_i | input | NF | Mask byte write data |
| flag_o | output | NF | Flag register |
| mask_o | output | NF | Mask register |
| irq_n_o | output | 1 | Active-low interrupt line |

## Verification
The bench builds the block with eight flags, the default mask-read set on bits 0 and 1, and `PULSE_CYC` set to 6. The short pulse makes the full low time, its natural end and an early end caused by a read all visible within a few cycles, so their exact edges can be compared. The eight-bit width lets a flag-only read keep some set bits and clear others, and lets events parked in a window overlap with flags that are cleared. The default pulse length is far longer and is only elaborated.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Kind of clear applied when a read window closes
  typedef enum logic [1:0] {
    CLR_NONE  = 2'd0,
    CLR_FLAGS = 2'd1,
    CLR_ALL   = 2'd2
  } clr_kind_e;

  // Width of a down-counter that must hold values 0..n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rd_window_trk.sv
module rd_window_trk
  import evt_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_start_i,
  input  logic      rd_flag_i,
  input  logic      rd_mask_i,
  input  logic      stop_i,
  output logic      hold_o,
  output clr_kind_e clr_o
);

  logic win_q, win_n;
  logic frd_q, frd_n;
  logic end_both, end_stop;

  assign end_both = win_q & rd_mask_i;
  assign end_stop = win_q & stop_i & ~rd_mask_i;

  always_comb begin
    win_n = win_q;
    frd_n = frd_q;
    if (end_both || end_stop) begin
      win_n = 1'b0;
      frd_n = 1'b0;
    end else if (win_q) begin
      if (rd_flag_i) frd_n = 1'b1;
    end else if (rd_start_i) begin
      win_n = 1'b1;
      frd_n = 1'b0;
    end
  end

  always_comb begin
    clr_o = CLR_NONE;
    if (end_both)                              clr_o = CLR_ALL;
    else if (end_stop && (frd_q || rd_flag_i)) clr_o = CLR_FLAGS;
  end

  assign hold_o = win_q & ~(end_both | end_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      frd_q <= 1'b0;
    end else begin
      win_q <= win_n;
      frd_q <= frd_n;
    end
  end

  // A clear may only be issued for a window that was open
  assert_clear_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != CLR_NONE) |-> win_q);

  // A closed window is closed on the next cycle
  assert_window_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !hold_o) |=> !win_q);

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_irq_pkg::*;
#(
  parameter int unsigned     NF      = 8,
  parameter logic [NF-1:0]   MRD_CLR = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt_i,
  input  logic          hold_i,
  input  clr_kind_e     clr_i,
  output logic [NF-1:0] flag_o
);

  logic [NF-1:0] flag_q, flag_n;
  logic [NF-1:0] pend_q, pend_n;
  logic [NF-1:0] clr_vec;

  always_comb begin
    unique case (clr_i)
      CLR_ALL:   clr_vec = '1;
      CLR_FLAGS: clr_vec = ~MRD_CLR;
      default:   clr_vec = '0;
    endcase
  end

  always_comb begin
    flag_n = flag_q;
    pend_n = pend_q;
    if (hold_i) begin
      pend_n = pend_q | evt_i;
    end else begin
      flag_n = (flag_q & ~clr_vec) | pend_q | evt_i;
      pend_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pend_q <= '0;
    end else begin
      flag_q <= flag_n;
      pend_q <= pend_n;
    end
  end

  assign flag_o = flag_q;

  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && clr_i == CLR_NONE) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(flag_q));

  assert_full_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == CLR_ALL) |=> ((flag_q & ~$past(pend_q | evt_i)) == '0));

  assert_keep_mrd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == CLR_FLAGS) |=>
      ((flag_q & MRD_CLR) == (($past(flag_q) | $past(pend_q) | $past(evt_i)) & MRD_CLR)));

endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int unsigned NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [NF-1:0] wdata_i,
  input  logic          clr_all_i,
  output logic [NF-1:0] mask_o
);

  logic [NF-1:0] mask_q, mask_n;
  logic          mask_en;

  assign mask_en = wr_i | clr_all_i;

  always_comb begin
    mask_n = mask_q;
    if (clr_all_i)  mask_n = '0;
    else if (wr_i)  mask_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_n;
  end

  assign mask_o = mask_q;

  assert_mask_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (mask_q == '0));

  assert_mask_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !clr_all_i) |=> $stable(mask_q));

endmodule

// File: rtl/irq_oneshot.sv
module irq_oneshot
  import evt_irq_pkg::*;
#(
  parameter int unsigned NF        = 8,
  parameter int unsigned PULSE_CYC = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flag_i,
  input  logic [NF-1:0] mask_i,
  input  logic          clr_all_i,
  input  logic          mask_wr_i,
  output logic          irq_n_o
);

  localparam int unsigned CW = cnt_width(PULSE_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

  logic          pulse_q, pulse_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          armed_q, armed_n;
  logic          seen_q, seen_n;
  logic          fire;
  logic          pulse_en;

  assign fire     = armed_q & ~pulse_q & ~clr_all_i & (|(flag_i & mask_i));
  assign pulse_en = fire | pulse_q;

  always_comb begin
    pulse_n = pulse_q;
    cnt_n   = cnt_q;
    if (fire) begin
      pulse_n = 1'b1;
      cnt_n   = CNT_LOAD;
    end else if (pulse_q) begin
      if (clr_all_i || cnt_q == '0) pulse_n = 1'b0;
      else                          cnt_n   = cnt_q - 1'b1;
    end
  end

  always_comb begin
    armed_n = armed_q;
    seen_n  = seen_q;
    if (fire) begin
      armed_n = 1'b0;
    end else if (mask_wr_i && seen_q) begin
      armed_n = 1'b1;
      seen_n  = 1'b0;
    end
    if (clr_all_i) seen_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_n;
      cnt_q   <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      armed_q <= armed_n;
      seen_q  <= seen_n;
    end
  end

  assign irq_n_o = ~pulse_q;

  // Checker-side run-length counter of the low time
  logic [31:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= '0;
    else if (pulse_q)  low_run_q <= low_run_q + 1;
    else               low_run_q <= '0;
  end

  assert_low_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= PULSE_CYC);

  assert_fire_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(armed_q));

  assert_fire_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> !armed_q);

  assert_read_ends_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> !pulse_q);

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned   NF        = 8,
  parameter logic [NF-1:0] MRD_CLR   = 8'h03,
  parameter int unsigned   PULSE_CYC = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt_i,
  input  logic          rd_start_i,
  input  logic          rd_flag_i,
  input  logic          rd_mask_i,
  input  logic          stop_i,
  input  logic          mask_wr_i,
  input  logic [NF-1:0] mask_wdata_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] mask_o,
  output logic          irq_n_o
);

  logic          hold;
  clr_kind_e     clr_kind;
  logic          clr_all;
  logic [NF-1:0] flag_w;
  logic [NF-1:0] mask_w;

  assign clr_all = (clr_kind == CLR_ALL);

  rd_window_trk u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start_i (rd_start_i),
    .rd_flag_i  (rd_flag_i),
    .rd_mask_i  (rd_mask_i),
    .stop_i     (stop_i),
    .hold_o     (hold),
    .clr_o      (clr_kind)
  );

  evt_flag_bank #(.NF(NF), .MRD_CLR(MRD_CLR)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .hold_i (hold),
    .clr_i  (clr_kind),
    .flag_o (flag_w)
  );

  evt_mask_reg #(.NF(NF)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (mask_wr_i),
    .wdata_i   (mask_wdata_i),
    .clr_all_i (clr_all),
    .mask_o    (mask_w)
  );

  irq_oneshot #(.NF(NF), .PULSE_CYC(PULSE_CYC)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_i    (flag_w),
    .mask_i    (mask_w),
    .clr_all_i (clr_all),
    .mask_wr_i (mask_wr_i),
    .irq_n_o   (irq_n_o)
  );

  assign flag_o = flag_w;
  assign mask_o = mask_w;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n_o && flag_o == '0 && mask_o == '0));

  assert_unmasked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_o) == '0 && mask_o == '0 && irq_n_o) |=> irq_n_o);

endmodule

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;

  localparam int NF = 8;
  localparam int PC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] evt = '0;
  logic          rd_start = 1'b0, rd_flag = 1'b0, rd_mask = 1'b0, stop = 1'b0;
  logic          mask_wr = 1'b0;
  logic [NF-1:0] mask_wdata = '0;
  logic [NF-1:0] flag_o, mask_o;
  logic          irq_n_o;

  always #2 clk = ~clk;

  evt_irq_ctrl #(.NF(NF), .MRD_CLR(8'h03), .PULSE_CYC(PC)) u_evt_irq_ctrl (
    .clk (clk), .rst_n (rst_n), .evt_i (evt),
    .rd_start_i (rd_start), .rd_flag_i (rd_flag), .rd_mask_i (rd_mask),
    .stop_i (stop), .mask_wr_i (mask_wr), .mask_wdata_i (mask_wdata),
    .flag_o (flag_o), .mask_o (mask_o), .irq_n_o (irq_n_o)
  );

  typedef struct {
    int            due;
    logic [NF-1:0] f;
    logic [NF-1:0] m;
    logic          i;
    string         tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares expected items one ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.due != cyc || flag_o !== e.f || mask_o !== e.m || irq_n_o !== e.i) begin
          errors++;
          $display("FAIL %s cyc=%0d: actual flag=%h mask=%h irq_n=%b expected flag=%h mask=%h irq_n=%b",
                   e.tag, cyc, flag_o, mask_o, irq_n_o, e.f, e.m, e.i);
        end
      end
    end
  end

  task automatic expect_st(input int k, input logic [NF-1:0] f, input logic [NF-1:0] m,
                           input logic i, input string tag);
    exp_t e;
    e.due = cyc + k; e.f = f; e.m = m; e.i = i; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drv(input logic [NF-1:0] ev, input logic rs, input logic rf,
                     input logic rm, input logic sp, input logic mw,
                     input logic [NF-1:0] md);
    evt = ev; rd_start = rs; rd_flag = rf; rd_mask = rm; stop = sp;
    mask_wr = mw; mask_wdata = md;
    @(negedge clk);
    evt = '0; rd_start = 1'b0; rd_flag = 1'b0; rd_mask = 1'b0; stop = 1'b0;
    mask_wr = 1'b0; mask_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 queue: actual pending=%0d expected pending=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    expect_st(1, 8'h00, 8'h00, 1'b1, "R1");
    idle(2);

    // R2/R3: event with masks clear, no interrupt (polling)
    expect_st(1, 8'h10, 8'h00, 1'b1, "R2");
    expect_st(3, 8'h10, 8'h00, 1'b1, "R3");
    drv(8'h10, 0, 0, 0, 0, 0, 8'h00);
    idle(3);

    // R6/R4/R5: enabling mask on a set flag fires; pulse is bounded; no retrigger
    expect_st(1,  8'h10, 8'h10, 1'b1, "R6");
    expect_st(2,  8'h30, 8'h10, 1'b0, "R6");
    expect_st(7,  8'h30, 8'h10, 1'b0, "R4");
    expect_st(8,  8'h30, 8'h10, 1'b1, "R4");
    expect_st(11, 8'h30, 8'h10, 1'b1, "R5");
    drv(8'h00, 0, 0, 0, 0, 1, 8'h10);
    drv(8'h20, 0, 0, 0, 0, 0, 8'h00);
    drv(8'h10, 0, 0, 0, 0, 0, 8'h00);
    idle(5);
    drv(8'h10, 0, 0, 0, 0, 0, 8'h00);
    idle(3);

    // R10: mask write without a mask-byte read does not re-arm
    expect_st(1, 8'h30, 8'h30, 1'b1, "R10");
    expect_st(3, 8'h30, 8'h30, 1'b1, "R10");
    drv(8'h00, 0, 0, 0, 0, 1, 8'h30);
    idle(3);

    // R9/R8: events held in window; flag-only read keeps bits 0 and 1
    expect_st(1, 8'h31, 8'h30, 1'b1, "R2");
    expect_st(3, 8'h31, 8'h30, 1'b1, "R9");
    expect_st(5, 8'h43, 8'h30, 1'b1, "R8");
    drv(8'h01, 0, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 1, 0, 0, 0, 0, 8'h00);
    drv(8'h42, 0, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 1, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 0, 0, 1, 0, 8'h00);
    idle(2);

    // R7/R10/R4: full read clears, read then write re-arms, read ends pulse early
    expect_st(3, 8'h00, 8'h00, 1'b1, "R7");
    expect_st(4, 8'h00, 8'h04, 1'b1, "R10");
    expect_st(5, 8'h04, 8'h04, 1'b1, "R2");
    expect_st(6, 8'h04, 8'h04, 1'b0, "R10");
    expect_st(7, 8'h04, 8'h04, 1'b0, "R4");
    expect_st(8, 8'h00, 8'h00, 1'b1, "R7");
    drv(8'h00, 1, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 1, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 0, 1, 0, 0, 8'h00);
    drv(8'h00, 0, 0, 0, 0, 1, 8'h04);
    drv(8'h04, 0, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 1, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 1, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 0, 1, 0, 0, 8'h00);
    idle(2);

    // R9: stop with no byte delivered clears nothing, releases held event
    expect_st(1, 8'h08, 8'h00, 1'b1, "R2");
    expect_st(3, 8'h08, 8'h00, 1'b1, "R9");
    expect_st(4, 8'h88, 8'h00, 1'b1, "R9");
    drv(8'h08, 0, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 1, 0, 0, 0, 0, 8'h00);
    drv(8'h80, 0, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 0, 0, 1, 0, 8'h00);
    idle(2);

    // R7: event on the clearing edge survives the clear
    expect_st(2, 8'h88, 8'h00, 1'b1, "R9");
    expect_st(3, 8'h20, 8'h00, 1'b1, "R7");
    drv(8'h00, 1, 0, 0, 0, 0, 8'h00);
    drv(8'h00, 0, 1, 0, 0, 0, 8'h00);
    drv(8'h20, 0, 0, 1, 0, 0, 8'h00);
    idle(2);

    // R3: re-armed line with matching mask drives low
    expect_st(1, 8'h20, 8'h20, 1'b1, "R3");
    expect_st(2, 8'h20, 8'h20, 1'b0, "R3");
    expect_st(8, 8'h20, 8'h20, 1'b1, "R4");
    drv(8'h00, 0, 0, 0, 0, 1, 8'h20);
    idle(9);

    finish_run();
  end

endmodule